// File: doc/BRIEF.md
# Receive Holding Buffer with Split Host Read

This block sits between a serial word decoder and a 16-bit host bus. Each time the decoder strobes a finished word, the block either latches it into a holding buffer or, when the buffer still holds a word the host has not read, parks it in a single pending register. While the holding buffer is valid, an active-low ready flag is asserted.

The host reads the held word as two 16-bit halves. A select line picks the half, and an active-low output enable strobes the read. The ready flag clears on the falling edge of the enable pulse that completes the pair of reads. The halves may be read in either order, and repeated reads of the same half count once. A parked word moves into the buffer once the flag has cleared and the enable is back high. A word that arrives while one is already parked replaces the parked one; the latched word is never replaced.

The host strobes are treated as synchronous to `clk`, and the falling edge of `oe_n` is found by comparing it against its value at the previous clock. A word-length input selects the short 25-bit format. The short format is applied at the moment a word is accepted.

Top module: `rx_hold_buf`

## Requirements
- R1: While `rst_n` is low and after its release, `dr_n` is high, `rd_drive` is low, and any parked word is discarded, so `dr_n` stays high until a new word is strobed.
- R2: A `dec_valid` strobe into an empty buffer with nothing parked and `oe_n` high drives `dr_n` low from the next clock edge.
- R3: With `sel` = 0 the read returns serial bits 1–16 (`dec_word[15:0]`). With `sel` = 1 it returns bits 17–32 (`dec_word[31:16]`).
- R4: `rd_drive` is high exactly while `oe_n` is low. `rd_data` is all zeros while `oe_n` is high.
- R5: `dr_n` goes high at the clock edge that samples the falling edge of the `oe_n` pulse completing reads of both halves, in either order.
- R6: Reading the same half again, however many times, does not clear `dr_n`.
- R7: A word strobed while `dr_n` is low leaves the held word unchanged, and it is parked.
- R8: A parked word enters the buffer at the first clock edge at which `dr_n` is high and `oe_n` is high, driving `dr_n` low again.
- R9: A second word strobed while one is already parked replaces the parked word.
- R10: With `short_mode` = 1 at acceptance, bits 26–32 of the word (`rd_data[15:9]` of the `sel` = 1 half) read as zero.
- R11: `oe_n` pulses while `dr_n` is high count toward no later clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_word | input | 32 | Decoded word, serial bit 1 in bit 0 |
| dec_valid | input | 1 | One-cycle strobe: `dec_word` is a newly accepted word |
| short_mode | input | 1 | 1 selects the 25-bit word format |
| sel | input | 1 | Half select: 0 = bits 1–16, 1 = bits 17–32 |
| oe_n | input | 1 | Active-low read enable |
| rd_data | output | 16 | Selected half, zero when not enabled |
| rd_drive | output | 1 | Bus drive enable for an external pad |
| dr_n | output | 1 | Active-low data-ready flag |

## Verification
The bench reads the halves in both orders and repeats one half. A design that counts strobes instead of halves would clear the flag early. It strobes a second word before the first is read and then a third. A design that overwrites the held word, or keeps the older parked word, returns the wrong data on the next read.

It also keeps the final enable low across the clear while a word is parked. A design that moves the parked word in too early would change `rd_data` in the middle of a read. Reads while the buffer is empty are followed by a single-half read, which would wrongly clear the flag if such stray reads were counted.

// File: rtl/rxhb_pkg.sv
package rxhb_pkg;
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_e;

   function automatic logic [1:0] half_bit(input logic s);
      return (s == HALF_HI) ? 2'b10 : 2'b01;
   endfunction
endpackage

// File: rtl/rxhb_read_track.sv
module rxhb_read_track
   import rxhb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   input  logic sel,
   input  logic buf_valid,
   output logic release_rdy
);
   logic       oe_prev_q;
   logic [1:0] got_q;
   logic [1:0] got_nxt;
   logic       oe_fall;
   logic       mark;

   assign oe_fall     = oe_prev_q & ~oe_n;
   assign mark        = oe_fall & buf_valid;
   assign got_nxt     = got_q | half_bit(sel);
   assign release_rdy = mark & (&got_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_prev_q <= 1'b1;
         got_q     <= 2'b00;
      end else begin
         oe_prev_q <= oe_n;
         if (release_rdy)
            got_q <= 2'b00;
         else if (mark)
            got_q <= got_nxt;
      end
   end

   // R11: no half is remembered while nothing is held
   p_flags_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_valid |-> (got_q == 2'b00));
   // R6: a clear only follows a fresh leading edge
   p_release_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      release_rdy |-> (oe_prev_q && !oe_n));
endmodule

// File: rtl/rxhb_store.sv
module rxhb_store #(
   parameter int WORD_W  = 32,
   parameter int SHORT_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] dec_word,
   input  logic              dec_valid,
   input  logic              short_mode,
   input  logic              oe_idle,
   input  logic              release_rdy,
   output logic [WORD_W-1:0] buf_q,
   output logic              buf_valid
);
   localparam logic [WORD_W-1:0] SHORT_MASK = {{(WORD_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

   logic [WORD_W-1:0] word_in;
   logic [WORD_W-1:0] pend_q;
   logic              pend_v;
   logic              can_move;
   logic              direct;

   generate
      if (SHORT_W < WORD_W) begin : g_mask
         assign word_in = short_mode ? (dec_word & SHORT_MASK) : dec_word;
      end else begin : g_nomask
         logic unused_short;
         assign unused_short = short_mode;
         assign word_in      = dec_word;
      end
   endgenerate

   assign can_move = ~buf_valid & pend_v & oe_idle;
   assign direct   = dec_valid & ~buf_valid & ~pend_v & oe_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q     <= '0;
         buf_valid <= 1'b0;
         pend_q    <= '0;
         pend_v    <= 1'b0;
      end else begin
         if (release_rdy)
            buf_valid <= 1'b0;
         if (can_move) begin
            buf_q     <= pend_q;
            buf_valid <= 1'b1;
            pend_v    <= 1'b0;
         end
         if (direct) begin
            buf_q     <= word_in;
            buf_valid <= 1'b1;
         end
         if (dec_valid && !direct) begin
            pend_q <= word_in;
            pend_v <= 1'b1;
         end
      end
   end

   // R2: a word into an empty store becomes valid next edge
   p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !buf_valid && !pend_v && oe_idle) |=> buf_valid);
   // R7: a held word is never replaced before release
   p_held_word_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !release_rdy) |=> (buf_valid && $stable(buf_q)));
   // R9: parked word changes only by a new strobe
   p_pend_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !dec_valid && !can_move) |=> (pend_v && $stable(pend_q)));
   // R8: a move never happens during a read
   p_move_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !buf_valid && !oe_idle) |=> !buf_valid);
endmodule

// File: rtl/rxhb_out_mux.sv
module rxhb_out_mux #(
   parameter int WORD_W = 32,
   parameter int HALF_W = 16
) (
   input  logic [WORD_W-1:0] buf_q,
   input  logic              sel,
   input  logic              oe_n,
   output logic [HALF_W-1:0] rd_data,
   output logic              rd_drive
);
   localparam int HALVES = WORD_W / HALF_W;

   logic [HALF_W-1:0] half_w [HALVES];

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         assign half_w[h] = buf_q[h*HALF_W +: HALF_W];
      end
   endgenerate

   assign rd_drive = ~oe_n;
   assign rd_data  = oe_n ? '0 : half_w[sel];
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
   parameter int WORD_W  = 32,
   parameter int HALF_W  = 16,
   parameter int SHORT_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] dec_word,
   input  logic              dec_valid,
   input  logic              short_mode,
   input  logic              sel,
   input  logic              oe_n,
   output logic [HALF_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              dr_n
);
   initial begin
      if (WORD_W != 2 * HALF_W)
         $error("rx_hold_buf: WORD_W must be two halves");
      if (SHORT_W <= HALF_W || SHORT_W > WORD_W)
         $error("rx_hold_buf: SHORT_W out of range");
   end

   logic [WORD_W-1:0] buf_q;
   logic              buf_valid;
   logic              release_rdy;

   rxhb_read_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .oe_n        (oe_n),
      .sel         (sel),
      .buf_valid   (buf_valid),
      .release_rdy (release_rdy)
   );

   rxhb_store #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .dec_word    (dec_word),
      .dec_valid   (dec_valid),
      .short_mode  (short_mode),
      .oe_idle     (oe_n),
      .release_rdy (release_rdy),
      .buf_q       (buf_q),
      .buf_valid   (buf_valid)
   );

   rxhb_out_mux #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_mux (
      .buf_q    (buf_q),
      .sel      (sel),
      .oe_n     (oe_n),
      .rd_data  (rd_data),
      .rd_drive (rd_drive)
   );

   assign dr_n = ~buf_valid;

   // R5: flag clears only while a read is in progress
   p_clear_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dr_n) |-> !$past(oe_n));
   // R4: bus not driven while enable is high
   p_idle_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rd_drive && rd_data == '0));
endmodule

// File: tb/rx_hold_buf_tb_top.sv
module rx_hold_buf_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] dec_word;
   logic        dec_valid;
   logic        short_mode;
   logic        sel;
   logic        oe_n;
   logic [15:0] rd_data;
   logic        rd_drive;
   logic        dr_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rx_hold_buf dut_i (
      .clk(clk), .rst_n(rst_n), .dec_word(dec_word), .dec_valid(dec_valid),
      .short_mode(short_mode), .sel(sel), .oe_n(oe_n),
      .rd_data(rd_data), .rd_drive(rd_drive), .dr_n(dr_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] w, input logic s);
      @(negedge clk);
      dec_word = w; short_mode = s; dec_valid = 1'b1;
      @(negedge clk);
      dec_valid = 1'b0;
   endtask

   // one-cycle read pulse; returns at negedge after the sampling edge
   task automatic rd(input logic s, output logic [15:0] d);
      @(negedge clk);
      sel = s; oe_n = 1'b0;
      #1;
      d = rd_data;
      chk("R4 drive during read", {31'b0, rd_drive}, 32'd1);
      @(negedge clk);
      oe_n = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; dec_valid = 1'b0; dec_word = '0; short_mode = 1'b0;
      sel = 1'b0; oe_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      do_reset();
      chk("R1 dr_n after reset", {31'b0, dr_n}, 32'd1);
      chk("R1 rd_drive after reset", {31'b0, rd_drive}, 32'd0);
      push(32'h1111_2222, 1'b0);
      push(32'h3333_4444, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 dr_n in reset", {31'b0, dr_n}, 32'd1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 parked word discarded", {31'b0, dr_n}, 32'd1);
      rd(1'b0, d);
   endtask

   task automatic t_basic();
      logic [15:0] d;
      do_reset();
      push(32'hA5C3_0F96, 1'b0);
      chk("R2 dr_n low after strobe", {31'b0, dr_n}, 32'd0);
      rd(1'b0, d);
      chk("R3 low half", {16'b0, d}, 32'h0F96);
      chk("R5 dr_n held after one half", {31'b0, dr_n}, 32'd0);
      rd(1'b1, d);
      chk("R3 high half", {16'b0, d}, 32'hA5C3);
      chk("R5 dr_n high after both", {31'b0, dr_n}, 32'd1);
   endtask

   task automatic t_reverse();
      logic [15:0] d;
      do_reset();
      push(32'h1234_5678, 1'b0);
      rd(1'b1, d);
      chk("R3 high half first", {16'b0, d}, 32'h1234);
      rd(1'b0, d);
      chk("R3 low half second", {16'b0, d}, 32'h5678);
      chk("R5 reverse order clears", {31'b0, dr_n}, 32'd1);
   endtask

   task automatic t_repeat();
      logic [15:0] d;
      do_reset();
      push(32'hDEAD_BEEF, 1'b0);
      rd(1'b0, d);
      rd(1'b0, d);
      rd(1'b0, d);
      chk("R6 repeated low half keeps flag", {31'b0, dr_n}, 32'd0);
      rd(1'b1, d);
      chk("R6 other half clears", {31'b0, dr_n}, 32'd1);
   endtask

   task automatic t_drive();
      do_reset();
      push(32'hFFFF_FFFF, 1'b0);
      @(negedge clk);
      sel = 1'b0;
      #1;
      chk("R4 no drive when idle", {31'b0, rd_drive}, 32'd0);
      chk("R4 zero data when idle", {16'b0, rd_data}, 32'd0);
   endtask

   task automatic t_pending();
      logic [15:0] d;
      do_reset();
      push(32'hAAAA_0001, 1'b0);
      push(32'hBBBB_0002, 1'b0);
      rd(1'b0, d);
      chk("R7 held low half kept", {16'b0, d}, 32'h0001);
      rd(1'b1, d);
      chk("R7 held high half kept", {16'b0, d}, 32'hAAAA);
      chk("R8 dr_n high at clear", {31'b0, dr_n}, 32'd1);
      @(negedge clk);
      chk("R8 parked word loaded", {31'b0, dr_n}, 32'd0);
      rd(1'b0, d);
      chk("R8 parked low half", {16'b0, d}, 32'h0002);
      rd(1'b1, d);
      chk("R8 parked high half", {16'b0, d}, 32'hBBBB);
   endtask

   task automatic t_overwrite();
      logic [15:0] d;
      do_reset();
      push(32'h0000_00C1, 1'b0);
      push(32'h0000_00C2, 1'b0);
      push(32'h0000_00C3, 1'b0);
      rd(1'b0, d);
      chk("R9 held word still first", {16'b0, d}, 32'h00C1);
      rd(1'b1, d);
      @(negedge clk);
      rd(1'b0, d);
      chk("R9 newest parked word wins", {16'b0, d}, 32'h00C3);
   endtask

   task automatic t_held_read();
      logic [15:0] d;
      do_reset();
      push(32'h5555_0011, 1'b0);
      push(32'h6666_0022, 1'b0);
      rd(1'b0, d);
      @(negedge clk);
      sel = 1'b1; oe_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 data steady while enable held", {16'b0, rd_data}, 32'h5555);
      chk("R8 no move while enable held", {31'b0, dr_n}, 32'd1);
      oe_n = 1'b1;
      @(negedge clk);
      chk("R8 move after enable high", {31'b0, dr_n}, 32'd0);
      rd(1'b1, d);
      chk("R8 moved word high half", {16'b0, d}, 32'h6666);
   endtask

   task automatic t_short();
      logic [15:0] d;
      do_reset();
      push(32'hFFFF_FFFF, 1'b1);
      rd(1'b1, d);
      chk("R10 short high half masked", {16'b0, d}, 32'h01FF);
      rd(1'b0, d);
      chk("R10 short low half", {16'b0, d}, 32'hFFFF);
      push(32'hFFFF_FFFF, 1'b0);
      rd(1'b1, d);
      chk("R10 long high half unmasked", {16'b0, d}, 32'hFFFF);
   endtask

   task automatic t_empty_reads();
      logic [15:0] d;
      do_reset();
      rd(1'b0, d);
      rd(1'b1, d);
      push(32'h0BAD_F00D, 1'b0);
      rd(1'b1, d);
      chk("R11 stray reads ignored", {31'b0, dr_n}, 32'd0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_reverse();
      t_repeat();
      t_drive();
      t_pending();
      t_overwrite();
      t_held_read();
      t_short();
      t_empty_reads();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule